// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block sits on the device side of a three-wire serial configuration link. The three wires are a serial clock, a latch line and a bidirectional data line. A host sends 16-bit frames made of a 7-bit register address, a direction bit and 8 data bits. The block holds a bank of thirty-six 8-bit configuration registers. It writes the addressed register when a write frame completes. For a read frame, it turns the data line around and shifts the addressed register back to the host.

All three link signals are asynchronous to the block's system clock. They are resynchronised and sampled, and the serial clock edges are detected in the system clock domain. The whole register bank is also presented as one wide parallel bus, so downstream logic can use the configuration directly. A one-cycle strobe, together with the written address, tells that logic which register has just changed.

Top module: `cfg3w_slave`

## Requirements
- R1: After reset every register reads zero, the data-line output enable is low, and no write strobe is raised.
- R2: A frame is captured on falling serial-clock edges. The first 7 bits are the address, most significant bit (A6) first, and they arrive with the latch line low. The 8th bit is the direction bit, also with the latch line low: 1 means write, 0 means read. The last 8 bits are data, most significant bit first, with the latch line high.
- R3: A write changes the addressed register only when the final data bit (D0) is captured. A frame cut short before D0 leaves every register unchanged.
- R4: Each committed write raises `wr_stb_o` for exactly one system clock. While it is high, `wr_addr_o` carries the written address.
- R5: In a read frame, the block drives the addressed register onto `sdata_o` with `sdata_oe_o` high for the 8 data periods, most significant bit first. Each bit changes after a rising serial-clock edge, so it is stable at the next falling edge. A read never changes any register.
- R6: The output enable is released after D0 of a read frame is captured, and also whenever the latch line falls.
- R7: A write to an address from 36 to 127 changes no register and raises no strobe. A read from such an address returns zero.
- R8: A falling edge on the latch line restarts the frame. The bits of a partial frame received before it are discarded, and the next 16 bits form a fresh frame.
- R9: If an address or direction bit is captured while the latch line is high, the frame is abandoned. It neither writes nor drives the data line until the latch line next falls.
- R10: Serial clock edges that arrive after D0 and before the next latch fall are ignored.
- R11: `regs_o` presents register k on bits [8k+7:8k].

Register contents are checked on parallel bus `regs_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| latch_i | input | 1 | Latch line: low during the address and direction bits, high during data |
| sdata_i | input | 1 | Serial data from the host |
| sdata_o | output | 1 | Serial read data toward the host |
| sdata_oe_o | output | 1 | Enable for the data-line driver |
| regs_o | output | 288 | All registers in parallel, register k at [8k+7:8k] |
| wr_stb_o | output | 1 | One-cycle pulse on each committed write |
| wr_addr_o | output | 7 | Address of the committed write |

## Verification
The bound checker enforces several rules on every cycle:
- the strobe is a single-cycle pulse;
- a strobe never names an address beyond the bank;
- the register bus never changes except right after a strobe;
- the data line is never driven when a write commits;
- outputs are quiet right after reset.

Other behaviours span a whole frame, and only the bench scenarios can show them. These are the bit ordering of address and data, commitment at D0 and nothing earlier, the read-back sequence and its enable window, discarding after a latch fall, abandonment on a latch-level mismatch, and the ignoring of surplus clocks.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

  localparam int DEF_NREGS = 36;
  localparam int DEF_AW    = 7;
  localparam int DEF_DW    = 8;
  localparam int DEF_SYNC  = 2;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DIR  = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Phase of the next bit to be captured, given how many were already taken.
  function automatic phase_e frame_phase(input int taken, input int aw, input int dw);
    if (taken < aw)               return PH_ADDR;
    else if (taken == aw)         return PH_DIR;
    else if (taken < aw + 1 + dw) return PH_DATA;
    else                          return PH_DONE;
  endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/cfg3w_regbank.sv
module cfg3w_regbank #(
  parameter int NREGS = 36,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [AW-1:0]       raddr,
  output logic [DW-1:0]       rdata,
  output logic [NREGS*DW-1:0] regs_flat
);

  logic [DW-1:0] mem [NREGS];

  genvar k;
  generate
    for (k = 0; k < NREGS; k++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                         mem[k] <= '0;
        else if (we && waddr == AW'(k))  mem[k] <= wdata;
      end
      assign regs_flat[k*DW +: DW] = mem[k];
    end
  endgenerate

  // Out-of-range addresses fall through to zero.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (raddr == AW'(i)) rdata = mem[i];
    end
  end

endmodule

// File: rtl/cfg3w_frame.sv
module cfg3w_frame
  import cfg3w_pkg::*;
#(
  parameter int NREGS = 36,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          latch_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          cmt_vld,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_data,
  output logic          sdo,
  output logic          sdo_oe
);

  localparam int FRAME = AW + 1 + DW;
  localparam int CW    = $clog2(FRAME + 1);

  logic          sclk_d, latch_d;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_sh;
  logic [DW-2:0] data_sh;
  logic [DW-1:0] rd_sh;
  logic          dir_wr;
  logic          abort;

  logic   sclk_fall, sclk_rise, latch_fall;
  phase_e ph;
  logic   level_ok;
  logic   last_bit;

  always_comb begin
    sclk_fall  = sclk_d & ~sclk_s;
    sclk_rise  = ~sclk_d & sclk_s;
    latch_fall = latch_d & ~latch_s;
    ph         = frame_phase(int'(cnt), AW, DW);
    level_ok   = (ph == PH_DATA) ? latch_s : ~latch_s;
    last_bit   = (int'(cnt) == FRAME - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      latch_d  <= 1'b0;
      cnt      <= '0;
      addr_sh  <= '0;
      data_sh  <= '0;
      rd_sh    <= '0;
      dir_wr   <= 1'b0;
      abort    <= 1'b0;
      cmt_vld  <= 1'b0;
      cmt_addr <= '0;
      cmt_data <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      latch_d <= latch_s;
      cmt_vld <= 1'b0;
      if (latch_fall) begin
        cnt    <= '0;
        abort  <= 1'b0;
        sdo_oe <= 1'b0;
      end else if (sclk_fall && ph != PH_DONE) begin
        cnt <= cnt + 1'b1;
        if (abort || !level_ok) begin
          abort  <= 1'b1;
          sdo_oe <= 1'b0;
        end else begin
          unique case (ph)
            PH_ADDR: addr_sh <= {addr_sh[AW-2:0], sdi_s};
            PH_DIR: begin
              dir_wr <= sdi_s;
              rd_sh  <= rd_data;
            end
            PH_DATA: begin
              data_sh <= {data_sh[DW-3:0], sdi_s};
              if (last_bit) begin
                sdo_oe <= 1'b0;
                if (dir_wr && int'(addr_sh) < NREGS) begin
                  cmt_vld  <= 1'b1;
                  cmt_addr <= addr_sh;
                  cmt_data <= {data_sh, sdi_s};
                end
              end
            end
            default: ;
          endcase
        end
      end else if (sclk_rise && !abort && !dir_wr && ph == PH_DATA) begin
        sdo_oe <= 1'b1;
        sdo    <= rd_sh[DW-1];
        rd_sh  <= {rd_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign rd_addr = addr_sh;

endmodule

// File: rtl/cfg3w_slave.sv
module cfg3w_slave #(
  parameter int NREGS = 36,
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int SYNC  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_i,
  input  logic                latch_i,
  input  logic                sdata_i,
  output logic                sdata_o,
  output logic                sdata_oe_o,
  output logic [NREGS*DW-1:0] regs_o,
  output logic                wr_stb_o,
  output logic [AW-1:0]       wr_addr_o
);

  logic [2:0]    pins_s;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          cmt_vld;
  logic [AW-1:0] cmt_addr;
  logic [DW-1:0] cmt_data;

  cfg3w_sync #(.W(3), .STAGES(SYNC)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({sdata_i, latch_i, sclk_i}),
    .sync_o  (pins_s)
  );

  cfg3w_frame #(.NREGS(NREGS), .AW(AW), .DW(DW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[0]),
    .latch_s  (pins_s[1]),
    .sdi_s    (pins_s[2]),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .cmt_vld  (cmt_vld),
    .cmt_addr (cmt_addr),
    .cmt_data (cmt_data),
    .sdo      (sdata_o),
    .sdo_oe   (sdata_oe_o)
  );

  cfg3w_regbank #(.NREGS(NREGS), .AW(AW), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (cmt_vld),
    .waddr     (cmt_addr),
    .wdata     (cmt_data),
    .raddr     (rd_addr),
    .rdata     (rd_data),
    .regs_flat (regs_o)
  );

  assign wr_stb_o  = cmt_vld;
  assign wr_addr_o = cmt_addr;

endmodule

// File: rtl/cfg3w_slave_chk.sv
module cfg3w_slave_chk #(
  parameter int NREGS = 36,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                sdata_oe_o,
  input logic [NREGS*DW-1:0] regs_o,
  input logic                wr_stb_o,
  input logic [AW-1:0]       wr_addr_o
);

  AST_OUTPUTS_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sdata_oe_o && !wr_stb_o)); // R1

  AST_REGS_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_o |=> $stable(regs_o)); // R3

  AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o); // R4

  AST_NO_DRIVE_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> !sdata_oe_o); // R5

  AST_STROBE_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> (int'(wr_addr_o) < NREGS)); // R7

endmodule

bind cfg3w_slave cfg3w_slave_chk #(.NREGS(NREGS), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sdata_oe_o (sdata_oe_o),
  .regs_o     (regs_o),
  .wr_stb_o   (wr_stb_o),
  .wr_addr_o  (wr_addr_o)
);

// File: tb/cfg3w_slave_tb.sv
module cfg3w_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 36;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int H = 8;   // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b1, latch_i = 1'b1, sdata_i = 1'b1;
  logic sdata_o, sdata_oe_o, wr_stb_o;
  logic [NREGS*DW-1:0] regs_o;
  logic [AW-1:0] wr_addr_o;

  int total = 0, failed = 0;
  int stb_cnt = 0;
  int last_addr = -1;
  logic cmp_en = 1'b0;
  logic [7:0] model [NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg3w_slave u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .latch_i(latch_i), .sdata_i(sdata_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .regs_o(regs_o),
    .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe monitor
  always @(negedge clk) begin
    if (!rst && wr_stb_o) begin
      stb_cnt++;
      last_addr = int'(wr_addr_o);
    end
  end

  // Per-clock comparison of the register bus with the model (R11 layout)
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      int bad = -1;
      for (int k = 0; k < NREGS; k++)
        if (regs_o[k*8 +: 8] !== model[k] && bad < 0) bad = k;
      check(bad < 0, "R11 register bus vs model",
            bad < 0 ? 0 : int'(regs_o[bad*8 +: 8]), bad < 0 ? 0 : int'(model[bad]));
    end
  end

  // One serial bit: data set up, sample read line, falling edge, rising edge.
  task automatic send_bit(input logic lat, input logic d, output logic rd, output logic oe);
    latch_i = lat;
    sdata_i = d;
    repeat (H) @(negedge clk);
    rd = sdata_o;
    oe = sdata_oe_o;
    sclk_i = 1'b0;
    repeat (H) @(negedge clk);
    sclk_i = 1'b1;
  endtask

  // lhi: first bit index sent with the latch line high (8 for a proper frame).
  task automatic run_frame(input logic [6:0] a, input logic rw, input logic [7:0] d,
                           input int nbits, input int lhi, input bit idle,
                           output logic [7:0] rv, output int oec);
    logic b, r, o;
    rv = '0;
    oec = 0;
    cmp_en = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i < 7)       b = a[6-i];
      else if (i == 7) b = rw;
      else if (i < 16) b = d[15-i];
      else             b = 1'b1;
      send_bit(i >= lhi, b, r, o);
      if (i >= 8 && i < 16) begin
        rv = {rv[6:0], r};
        if (o) oec++;
      end
    end
    if (idle) begin
      latch_i = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int oec, s0;
    for (int k = 0; k < NREGS; k++) model[k] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    // R1 reset state
    check(regs_o == '0, "R1 registers zero", 0, 0);
    check(sdata_oe_o == 1'b0, "R1 output enable low", int'(sdata_oe_o), 0);
    check(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);
    cmp_en = 1'b1;

    // R2/R4 basic writes at both ends of the bank
    s0 = stb_cnt;
    run_frame(7'd0, 1'b1, 8'hA5, 16, 8, 1, rv, oec);
    model[0] = 8'hA5;
    settle();
    check(regs_o[7:0] == 8'hA5, "R2 write reg0", int'(regs_o[7:0]), 'hA5);
    check(stb_cnt == s0 + 1, "R4 one strobe", stb_cnt - s0, 1);
    check(last_addr == 0, "R4 strobe address", last_addr, 0);
    check(oec == 0, "R5 no drive in write frame", oec, 0);
    s0 = stb_cnt;
    run_frame(7'd35, 1'b1, 8'h3C, 16, 8, 1, rv, oec);
    model[35] = 8'h3C;
    settle();
    check(regs_o[35*8 +: 8] == 8'h3C, "R2 write reg35", int'(regs_o[35*8 +: 8]), 'h3C);
    check(last_addr == 35 && stb_cnt == s0 + 1, "R4 strobe address 35", last_addr, 35);

    // R11 fill every register with a distinct pattern
    for (int k = 0; k < NREGS; k++) begin
      run_frame(7'(k), 1'b1, 8'(k * 7 + 1), 16, 8, 1, rv, oec);
      model[k] = 8'(k * 7 + 1);
      settle();
    end
    check(regs_o[17*8 +: 8] == 8'd120, "R11 reg17 position", int'(regs_o[17*8 +: 8]), 120);

    // R5/R6 read back
    s0 = stb_cnt;
    run_frame(7'd17, 1'b0, 8'hFF, 16, 8, 1, rv, oec);
    settle();
    check(rv == 8'd120, "R5 read data reg17", int'(rv), 120);
    check(oec == 8, "R5 enable over 8 data periods", oec, 8);
    check(sdata_oe_o == 1'b0, "R6 release after D0", int'(sdata_oe_o), 0);
    check(stb_cnt == s0, "R5 read makes no strobe", stb_cnt - s0, 0);
    run_frame(7'd2, 1'b0, 8'hFF, 16, 8, 1, rv, oec);
    settle();
    check(rv == 8'd15, "R5 read data reg2", int'(rv), 15);

    // R7 out-of-range
    s0 = stb_cnt;
    run_frame(7'd50, 1'b1, 8'h99, 16, 8, 1, rv, oec);
    settle();
    check(stb_cnt == s0, "R7 no strobe beyond bank", stb_cnt - s0, 0);
    run_frame(7'd100, 1'b0, 8'hFF, 16, 8, 1, rv, oec);
    settle();
    check(rv == 8'h00, "R7 read beyond bank is zero", int'(rv), 0);

    // R3 frame stopped before D0
    s0 = stb_cnt;
    run_frame(7'd9, 1'b1, 8'h77, 15, 8, 1, rv, oec);
    settle();
    check(regs_o[9*8 +: 8] == model[9], "R3 no commit before D0", int'(regs_o[9*8 +: 8]), int'(model[9]));
    check(stb_cnt == s0, "R3 no strobe before D0", stb_cnt - s0, 0);

    // R8 partial frame then fresh frame
    run_frame(7'h7F, 1'b1, 8'h00, 5, 8, 1, rv, oec);
    s0 = stb_cnt;
    run_frame(7'd4, 1'b1, 8'hC3, 16, 8, 1, rv, oec);
    model[4] = 8'hC3;
    settle();
    check(regs_o[4*8 +: 8] == 8'hC3, "R8 fresh frame after latch fall", int'(regs_o[4*8 +: 8]), 'hC3);
    check(last_addr == 4 && stb_cnt == s0 + 1, "R8 strobe on fresh frame", last_addr, 4);

    // R6 latch fall releases the line mid-read
    run_frame(7'd4, 1'b0, 8'hFF, 11, 8, 0, rv, oec);
    check(sdata_oe_o == 1'b1, "R6 driving mid-read", int'(sdata_oe_o), 1);
    latch_i = 1'b0;
    repeat (H) @(negedge clk);
    check(sdata_oe_o == 1'b0, "R6 release on latch fall", int'(sdata_oe_o), 0);
    latch_i = 1'b1;
    repeat (H) @(negedge clk);
    settle();

    // R9 latch high during address bits
    s0 = stb_cnt;
    run_frame(7'd6, 1'b1, 8'hEE, 16, 3, 1, rv, oec);
    settle();
    check(stb_cnt == s0, "R9 mismatched frame no strobe", stb_cnt - s0, 0);
    check(regs_o[6*8 +: 8] == model[6], "R9 reg6 unchanged", int'(regs_o[6*8 +: 8]), int'(model[6]));

    // R10 extra clocks after D0
    s0 = stb_cnt;
    run_frame(7'd5, 1'b1, 8'h5A, 20, 8, 1, rv, oec);
    model[5] = 8'h5A;
    settle();
    check(stb_cnt == s0 + 1, "R10 extra clocks add no strobe", stb_cnt - s0, 1);
    check(regs_o[5*8 +: 8] == 8'h5A, "R10 reg5 keeps frame data", int'(regs_o[5*8 +: 8]), 'h5A);

    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule